// File: doc/BRIEF.md
# Synchronous burst read output sequencer

This block sits on the memory side of a 16-bit multiplexed address/data bus. It plays back one synchronous burst read. A start request begins the burst. The block counts out a programmable initial latency and then presents 4, 8 or 16 words in order on its data output, together with a valid strobe. While it runs, it drives a WAIT busy indication back to the host. Each word is taken from an external word source, which the block addresses through a fetch index.

Two configuration bits shape the timing. The hold bit makes each data cycle last two clocks (1) or one clock (0). The early bit makes WAIT deassert one data cycle ahead of the first word (1) or together with it (0). Both bits are written through a small write port and reset to 1. A burst copies them only at the moment it starts.

At the end of the burst, the data output goes back to not-valid and WAIT is asserted again. WAIT then stays asserted until output enable is released, and the block only returns to idle at that point.

Top module: `burst_rd_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `dq_valid` and `dq_out` to 0, leaves WAIT inactive, aborts any burst in progress, and sets both configuration bits to 1, so the first burst after reset uses two-clock data cycles and early WAIT release.
- R2: When `start` is sampled high at clock edge k while the block is idle, the first word is valid after edge k+L, where L is `lat_clks` sampled at edge k. L must be at least 2.
- R3: With the hold bit at 1, each word stays valid and unchanged on `dq_out` for exactly two clocks.
- R4: With the hold bit at 0, each word stays valid for one clock, so a new word appears every clock.
- R5: The burst length code `blen_sel`, sampled at start, selects the word count: 0 selects 4 words, 1 selects 8, and 2 or 3 select 16. After the last word's data cycle, `dq_valid` returns to 0.
- R6: With the early bit at 1, WAIT deasserts after edge k+L-D, where D is the data cycle length in clocks. This is one data cycle before the first valid word.
- R7: With the early bit at 0, WAIT stays asserted through the whole latency and deasserts in the cycle in which the first word becomes valid. It stays deasserted while data is valid.
- R8: From the cycle in which `dq_valid` falls at the end of a burst, WAIT is asserted. It stays asserted until `oe_n` is sampled high at a clock edge, and the block is then idle.
- R9: `wait_o` shows its active level (1) only while `oe_n` and `ce_n` are both low. Otherwise it is 0, and this follows the pins within the same cycle.
- R10: The configuration bits are copied only when a burst starts. A write during a burst does not alter that burst and takes effect on the next one. `blen_sel` and `lat_clks` are likewise ignored after start.
- R11: A `start` pulse that arrives while a burst is in progress (latency, data or end phase) is ignored.
- R12: Word i of the burst is the value of `word_in` presented while `fetch_idx` equals i. Words come out in order 0, 1, 2 and so on. `dq_out` is 0 whenever `dq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_hold2 | input | 1 | New hold bit: 1 for two-clock data cycles, 0 for one-clock data cycles |
| cfg_early | input | 1 | New early bit: 1 releases WAIT one data cycle before the first word |
| start | input | 1 | Burst start request, honoured only when idle |
| lat_clks | input | 5 | Initial latency in clocks, at least 2 |
| blen_sel | input | 2 | Burst length code: 0 selects 4 words, 1 selects 8, 2 or 3 select 16 |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| word_in | input | 16 | Word returned by the source for `fetch_idx` |
| fetch_idx | output | 4 | Index of the next word to load |
| dq_out | output | 16 | Burst data, 0 when not valid |
| dq_valid | output | 1 | High while `dq_out` carries a word |
| wait_o | output | 1 | WAIT, 1 means busy |

## Verification
A latency counter that is off by one shifts the first `dq_valid` and the WAIT release by one clock. Because the bench compares every cycle of the burst, this shows within the first burst. A hold phase that is stuck or skipped changes how many clocks each word lasts by the second word. A word counter that is wrong changes the burst length, and the mistake appears exactly at the clock where `dq_valid` falls. A configuration copy taken at the wrong time only shows one burst later, as the wrong data cycle length or the wrong WAIT lead on the burst after the write.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LAT  = 2'd1,
      ST_DATA = 2'd2,
      ST_END  = 2'd3
   } brs_state_e;

   typedef struct packed {
      logic hold2;
      logic wait_early;
   } brs_cfg_t;

   localparam brs_cfg_t BRS_CFG_RST = '{hold2: 1'b1, wait_early: 1'b1};

   function automatic int unsigned brs_words(input logic [1:0] sel);
      case (sel)
         2'd0:    return 4;
         2'd1:    return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
   import brs_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     we,
   input  logic     hold_in,
   input  logic     early_in,
   input  logic     take,
   output brs_cfg_t snap
);

   brs_cfg_t cfg_q;
   brs_cfg_t snap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q  <= BRS_CFG_RST;
         snap_q <= BRS_CFG_RST;
      end else begin
         if (we)
            cfg_q <= '{hold2: hold_in, wait_early: early_in};
         if (take)
            snap_q <= cfg_q;
      end
   end

   assign snap = snap_q;

   AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(snap_q)); // R10

endmodule

// File: rtl/brs_lat_timer.sv
module brs_lat_timer #(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LAT_W-1:0] lat_in,
   input  logic             run,
   input  logic             hold2,
   output logic             done,
   output logic             early_zone
);

   logic [LAT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst)
         left_q <= '0;
      else if (load)
         left_q <= lat_in - LAT_W'(1);
      else if (run && (left_q != '0))
         left_q <= left_q - LAT_W'(1);
   end

   assign done       = (left_q == '0);
   assign early_zone = hold2 ? (left_q < LAT_W'(2)) : (left_q == '0);

   AST_LAT_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
      run && !load && !done |=> left_q == $past(left_q) - LAT_W'(1)); // R2

endmodule

// File: rtl/brs_beat_ctr.sv
module brs_beat_ctr #(
   parameter int IDX_W = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           clr,
   input  logic           run,
   input  logic           hold2,
   input  logic [IDX_W:0] nwords,
   output logic [IDX_W-1:0] widx,
   output logic           ph,
   output logic           adv,
   output logic           last
);

   logic [IDX_W-1:0] widx_q;
   logic             ph_q;
   logic             ph_end;

   assign ph_end = hold2 ? ph_q : 1'b1;
   assign adv    = run && ph_end;
   assign last   = adv && (widx_q == IDX_W'(nwords - (IDX_W+1)'(1)));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         widx_q <= '0;
         ph_q   <= 1'b0;
      end else if (run) begin
         if (ph_end) begin
            ph_q <= 1'b0;
            if (!last)
               widx_q <= widx_q + IDX_W'(1);
         end else begin
            ph_q <= 1'b1;
         end
      end
   end

   assign widx = widx_q;
   assign ph   = ph_q;

   AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (rst)
      run |-> ((IDX_W+1)'(widx_q) < nwords)); // R5

   AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (rst)
      run && !hold2 |-> !ph_q); // R4

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
   import brs_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int LAT_W         = 5,
   parameter int LAT_MIN       = 2,
   parameter int BURST_MAX     = 16,
   parameter bit WAIT_ACT_HIGH = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cfg_we,
   input  logic                         cfg_hold2,
   input  logic                         cfg_early,
   input  logic                         start,
   input  logic [LAT_W-1:0]             lat_clks,
   input  logic [1:0]                   blen_sel,
   input  logic                         oe_n,
   input  logic                         ce_n,
   input  logic [DATA_W-1:0]            word_in,
   output logic [$clog2(BURST_MAX)-1:0] fetch_idx,
   output logic [DATA_W-1:0]            dq_out,
   output logic                         dq_valid,
   output logic                         wait_o
);

   localparam int IDX_W = $clog2(BURST_MAX);
   localparam int NW_W  = IDX_W + 1;

   if (BURST_MAX < 16) begin : g_bad_burst
      $error("BURST_MAX must hold the longest burst of 16 words");
   end
   if (LAT_MIN < 2) begin : g_bad_latmin
      $error("LAT_MIN must be at least 2");
   end
   if (LAT_W < 2) begin : g_bad_latw
      $error("LAT_W too small for the minimum latency");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   brs_state_e           st_q;
   brs_cfg_t             snap;
   logic [NW_W-1:0]      nwords_q;
   logic [DATA_W-1:0]    dq_q;
   logic                 start_acc;
   logic                 lat_done;
   logic                 early_zone;
   logic                 enter_data;
   logic [IDX_W-1:0]     widx;
   logic                 beat_ph;
   logic                 beat_adv;
   logic                 beat_last;
   logic                 wait_busy;
   logic                 wait_gated;

   assign start_acc  = (st_q == ST_IDLE) && start;
   assign enter_data = (st_q == ST_LAT) && lat_done;

   brs_cfg_reg u_cfg (
      .clk      (clk),
      .rst      (rst),
      .we       (cfg_we),
      .hold_in  (cfg_hold2),
      .early_in (cfg_early),
      .take     (start_acc),
      .snap     (snap)
   );

   brs_lat_timer #(.LAT_W(LAT_W)) u_lat (
      .clk        (clk),
      .rst        (rst),
      .load       (start_acc),
      .lat_in     (lat_clks),
      .run        (st_q == ST_LAT),
      .hold2      (snap.hold2),
      .done       (lat_done),
      .early_zone (early_zone)
   );

   brs_beat_ctr #(.IDX_W(IDX_W)) u_beat (
      .clk    (clk),
      .rst    (rst),
      .clr    (enter_data),
      .run    (st_q == ST_DATA),
      .hold2  (snap.hold2),
      .nwords (nwords_q),
      .widx   (widx),
      .ph     (beat_ph),
      .adv    (beat_adv),
      .last   (beat_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         nwords_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q     <= ST_LAT;
               nwords_q <= NW_W'(brs_words(blen_sel));
            end
            ST_LAT:  if (lat_done)  st_q <= ST_DATA;
            ST_DATA: if (beat_last) st_q <= ST_END;
            ST_END:  if (oe_n)      st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         dq_q <= '0;
      else if (enter_data || (beat_adv && !beat_last))
         dq_q <= word_in;
   end

   assign fetch_idx = (st_q == ST_DATA) ? (widx + IDX_W'(1)) : '0;
   assign dq_valid  = (st_q == ST_DATA);
   assign dq_out    = dq_valid ? dq_q : '0;

   assign wait_busy  = ((st_q == ST_LAT) && !(snap.wait_early && early_zone))
                       || (st_q == ST_END);
   assign wait_gated = wait_busy && !oe_n && !ce_n;

   if (WAIT_ACT_HIGH) begin : g_wait_hi
      assign wait_o = wait_gated;
   end else begin : g_wait_lo
      assign wait_o = !wait_gated;
   end

   AST_LAT_MIN: assert property (@(posedge clk) disable iff (rst)
      start_acc |-> (lat_clks >= LAT_W'(LAT_MIN))); // R2

   AST_HOLD_TWO: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_DATA) && snap.hold2 && beat_ph |-> dq_q == $past(dq_q)); // R3

   AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_LAT) && snap.wait_early && lat_done |-> !wait_busy); // R6

   AST_END_WAIT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $fell(dq_valid) |-> (st_q == ST_END) && wait_busy); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_DATA) && start && !beat_last |=> (st_q == ST_DATA)); // R11

endmodule

// File: tb/burst_rd_seq_tb.sv
module burst_rd_seq_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic        cfg_hold2 = 1'b1;
   logic        cfg_early = 1'b1;
   logic        start = 1'b0;
   logic [4:0]  lat_clks = 5'd4;
   logic [1:0]  blen_sel = 2'd0;
   logic        oe_n = 1'b0;
   logic        ce_n = 1'b0;
   logic [15:0] word_in;
   logic [3:0]  fetch_idx;
   logic [15:0] dq_out;
   logic        dq_valid;
   logic        wait_o;
   logic [11:0] tag = 12'h000;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5ns clk = ~clk;

   assign word_in = {tag, fetch_idx};

   burst_rd_seq u_dut (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_hold2 (cfg_hold2),
      .cfg_early (cfg_early),
      .start     (start),
      .lat_clks  (lat_clks),
      .blen_sel  (blen_sel),
      .oe_n      (oe_n),
      .ce_n      (ce_n),
      .word_in   (word_in),
      .fetch_idx (fetch_idx),
      .dq_out    (dq_out),
      .dq_valid  (dq_valid),
      .wait_o    (wait_o)
   );

   // vector: hold, early, blen_sel[1:0], latency[4:0]
   localparam logic [8:0] VECS [0:6] = '{
      {1'b1, 1'b1, 2'd0, 5'd4},
      {1'b0, 1'b1, 2'd0, 5'd3},
      {1'b1, 1'b0, 2'd1, 5'd5},
      {1'b0, 1'b0, 2'd2, 5'd2},
      {1'b1, 1'b1, 2'd3, 5'd2},
      {1'b0, 1'b0, 2'd0, 5'd9},
      {1'b1, 1'b0, 2'd2, 5'd7}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic h, input logic e);
      @(negedge clk);
      cfg_we = 1'b1; cfg_hold2 = h; cfg_early = e;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // eh/ee: settings the burst is expected to use
   task automatic run_burst(input logic eh, input logic ee, input logic [1:0] bs,
                            input int l, input bit poke, input bit ce_off);
      int d;
      int n;
      int tot;
      logic       ev;
      logic       ew;
      logic [15:0] eo;
      d   = eh ? 2 : 1;
      n   = (bs == 2'd0) ? 4 : (bs == 2'd1) ? 8 : 16;
      tot = l + n * d + 3;
      tag = tag + 12'h1;
      @(negedge clk);
      chk("R8", "idle wait", 32'(wait_o), 32'd0);
      start = 1'b1; blen_sel = bs; lat_clks = 5'(l);
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < tot; j++) begin
         if (j > 0) @(negedge clk);
         ev = (j >= l) && (j < l + n * d);
         eo = ev ? {tag, 4'((j - l) / d)} : 16'h0;
         if (ce_off)          ew = 1'b0;
         else if (j < l)      ew = ee ? (j < l - d) : 1'b1;
         else if (ev)         ew = 1'b0;
         else                 ew = 1'b1;
         chk((j < l) ? "R2" : "R5", "dq_valid", 32'(dq_valid), 32'(ev));
         // R12 word order and zero when idle
         chk(eh ? "R3" : "R4", "dq_out", 32'(dq_out), 32'(eo));
         if (ce_off)
            chk("R9", "wait chip off", 32'(wait_o), 32'(ew));
         else if (j < l)
            chk(ee ? "R6" : "R7", "wait latency", 32'(wait_o), 32'(ew));
         else if (ev)
            chk("R7", "wait data", 32'(wait_o), 32'(ew));
         else
            chk("R8", "wait end", 32'(wait_o), 32'(ew));
         if (poke) begin
            // R10 and R11: disturb inputs mid-burst
            if (j == 1) begin
               cfg_we = 1'b1; cfg_hold2 = ~eh; cfg_early = ~ee; start = 1'b1;
               blen_sel = ~bs; lat_clks = 5'd12;
            end
            if (j == 2) begin
               cfg_we = 1'b0; start = 1'b0;
            end
            if (j == l + 1) start = 1'b1;
            if (j == l + 2) start = 1'b0;
         end
      end
   endtask

   task automatic end_burst();
      @(negedge clk);
      oe_n = 1'b1;
      #1ns;
      chk("R9", "wait with oe high", 32'(wait_o), 32'd0);
      @(negedge clk);
      oe_n = 1'b0;
      #1ns;
      chk("R8", "wait after release", 32'(wait_o), 32'd0);
      chk("R8", "valid after release", 32'(dq_valid), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", 32'(dq_valid), 32'd0);
      chk("R1", "data in reset", 32'(dq_out), 32'd0);
      chk("R1", "wait in reset", 32'(wait_o), 32'd0);
      rst = 1'b0;

      // R1 default configuration: two-clock hold, early release
      run_burst(1'b1, 1'b1, 2'd0, 4, 1'b0, 1'b0);
      end_burst();

      for (int v = 0; v < 7; v++) begin
         wr_cfg(VECS[v][8], VECS[v][7]);
         run_burst(VECS[v][8], VECS[v][7], VECS[v][6:5], int'(VECS[v][4:0]), 1'b0, 1'b0);
         end_burst();
      end

      // R10 write mid-burst, R11 start mid-burst
      wr_cfg(1'b1, 1'b0);
      run_burst(1'b1, 1'b0, 2'd1, 5, 1'b1, 1'b0);
      end_burst();
      run_burst(1'b0, 1'b1, 2'd0, 3, 1'b0, 1'b0);
      end_burst();

      // R9 chip disabled keeps WAIT inactive
      ce_n = 1'b1;
      run_burst(1'b0, 1'b1, 2'd0, 4, 1'b0, 1'b1);
      end_burst();
      ce_n = 1'b0;

      // R1 reset aborts a burst and restores defaults
      wr_cfg(1'b0, 1'b0);
      @(negedge clk);
      start = 1'b1; blen_sel = 2'd2; lat_clks = 5'd3;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1", "valid before reset", 32'(dq_valid), 32'd1);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "valid after reset", 32'(dq_valid), 32'd0);
      chk("R1", "data after reset", 32'(dq_out), 32'd0);
      chk("R1", "wait after reset", 32'(wait_o), 32'd0);
      rst = 1'b0;
      run_burst(1'b1, 1'b1, 2'd0, 3, 1'b0, 1'b0);
      end_burst();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule